// File: doc/BRIEF.md
# Timer-Clocked COP Watchdog

This block is a computer-operating-properly watchdog whose time base is the tick stream of an 8-bit system timer, not the bus clock. A small modulo counter advances once per timer tick. When the count reaches its final value and one more tick arrives, the block raises a one-cycle reset request toward the central reset logic. Software keeps the system alive by writing a one to the clear bit of the watchdog's register address, which restarts the count at zero.

The register is write-only. A bus read that targets the watchdog address is not answered by this block. Instead, a select output steers that read to the ROM data path. A sticky arming latch gates the function. It is set by a pulse on `arm_set` and cleared only by reset. While it is clear, the counter still runs, but no reset request leaves the block.

Top module: `cop_watchdog`

## Requirements
- R1: After reset, `cop_rst_req` is 0 and the count is zero, so the first request needs a full DIV (default 8) ticks after reset is released.
- R2: With the latch armed, the DIV-th tick after the last restart drives `cop_rst_req` high in the clock cycle that follows the tick's cycle.
- R3: A write (`bus_we`=1) to address REG_ADDR (default 0x1FF0) with bit 0 of `bus_wdata` set to 1 restarts the count at zero.
- R4: A write to REG_ADDR with bit 0 of `bus_wdata` equal to 0 leaves the count unchanged, whatever the other data bits are.
- R5: A write to any address other than REG_ADDR leaves the count unchanged.
- R6: When a clearing write and a tick occur in the same cycle, the clear wins. The count becomes zero and no request is issued for that tick.
- R7: `cop_rst_req` is high for exactly one clock cycle per timeout.
- R8: The arming latch is set by `arm_set` and stays set until reset. While it is clear, timeouts produce no request.
- R9: `rom_sel` is 1 in the same cycle as a read (`bus_re`=1) of REG_ADDR and 0 otherwise. Reads have no effect on the count.
- R10: After a timeout the count wraps to zero, so the next request follows after another DIV ticks.
- R11: Cycles without a tick or a clearing write leave the count unchanged, so idle gaps between ticks do not shift the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle timer tick enable |
| arm_set | input | 1 | Pulse that sets the arming latch |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| rom_sel | output | 1 | Steers a read of the watchdog address to ROM |
| cop_rst_req | output | 1 | One-cycle reset request to the reset logic |

## Verification
The count is hidden, and only the timing of `cop_rst_req` shows it. A wrong count therefore shows up as a request that arrives early, arrives late, or is missing. This is visible no later than DIV ticks after the last restart. The bench keeps an arithmetic count and compares the request cycle by cycle over sweeps of clear positions, idle gaps, ignored writes and reset points. A bad arming latch or a bad read decode shows at once on `cop_rst_req` or `rom_sel`.

// File: rtl/cop_pkg.sv
package cop_pkg;
   localparam int unsigned COP_ADDR_W  = 16;
   localparam int unsigned COP_DATA_W  = 8;
   localparam int unsigned COP_DIV     = 8;
   localparam int unsigned COP_CLR_BIT = 0;

   function automatic int unsigned cnt_width(input int unsigned div);
      return (div <= 2) ? 1 : $clog2(div);
   endfunction
endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode #(
   parameter int unsigned ADDR_W   = cop_pkg::COP_ADDR_W,
   parameter int unsigned DATA_W   = cop_pkg::COP_DATA_W,
   parameter int unsigned CLR_BIT  = cop_pkg::COP_CLR_BIT,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h1FF0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic              clr_pulse,
   output logic              rom_sel
);
   generate
      if (CLR_BIT >= DATA_W) begin : g_bad_bit
         $error("CLR_BIT outside data bus");
      end
   endgenerate

   logic hit;
   assign hit       = (bus_addr == REG_ADDR);
   assign clr_pulse = bus_we & hit & bus_wdata[CLR_BIT];
   assign rom_sel   = bus_re & hit;

   assert_clear_needs_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |-> (bus_wdata[CLR_BIT] && bus_we));
endmodule

// File: rtl/cop_divider.sv
module cop_divider #(
   parameter int unsigned DIV   = cop_pkg::COP_DIV,
   localparam int unsigned CNT_W = cop_pkg::cnt_width(DIV)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic timeout
);
   generate
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);
   assign timeout = tick & ~clr & at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
   end

   assert_clear_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(cnt_q));
   assert_wrap_after_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> (cnt_q == '0));
endmodule

// File: rtl/cop_arm_latch.sv
module cop_arm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   output logic armed
);
   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
   end

   assert_arm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
   parameter int unsigned ADDR_W  = cop_pkg::COP_ADDR_W,
   parameter int unsigned DATA_W  = cop_pkg::COP_DATA_W,
   parameter int unsigned DIV     = cop_pkg::COP_DIV,
   parameter int unsigned CLR_BIT = cop_pkg::COP_CLR_BIT,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h1FF0),
   parameter bit          REQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              arm_set,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic              rom_sel,
   output logic              cop_rst_req
);
   logic clr_pulse;
   logic timeout;
   logic armed;
   logic req_next;

   cop_bus_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_BIT(CLR_BIT), .REG_ADDR(REG_ADDR)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .clr_pulse(clr_pulse), .rom_sel(rom_sel)
   );

   cop_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_pulse), .timeout(timeout)
   );

   cop_arm_latch u_arm (
      .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .armed(armed)
   );

   assign req_next = timeout & armed;

   generate
      if (REQ_REG) begin : g_req_reg
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req_next;
         end
         assign cop_rst_req = req_q;

         assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cop_rst_req |=> !cop_rst_req);
         assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cop_rst_req |-> ($past(tick) && !$past(clr_pulse)));
         assert_req_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cop_rst_req |-> armed);
      end else begin : g_req_comb
         assign cop_rst_req = req_next;
      end
   endgenerate
endmodule

// File: tb/cop_watchdog_tb.sv
module cop_watchdog_tb;
   localparam int DIV = 8;
   localparam logic [15:0] RA = 16'h1FF0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, arm_set = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic rom_sel, cop_rst_req;

   int n_chk = 0, n_fail = 0;
   int cnt_m = 0;
   bit armed_m = 0;

   always #10 clk = ~clk;

   cop_watchdog u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .arm_set(arm_set),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .rom_sel(rom_sel), .cop_rst_req(cop_rst_req)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle; model advances arithmetically, request checked after the edge
   task automatic cyc(input bit tk, input bit we, input bit re,
                      input logic [15:0] a, input logic [7:0] d, input string tag);
      bit clr, exp_req;
      @(negedge clk);
      tick = tk; bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
      #1;
      chk(rom_sel, re && (a == RA), "R9");
      clr = we && (a == RA) && d[0];
      exp_req = 0;
      if (clr) cnt_m = 0;
      else if (tk) begin
         exp_req = (cnt_m == DIV-1) && armed_m;
         cnt_m = (cnt_m + 1) % DIV;
      end
      @(posedge clk); #2;
      tick = 0; bus_we = 0; bus_re = 0;
      chk(cop_rst_req, exp_req, tag);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
      cnt_m = 0; armed_m = 0;
      #1 chk(cop_rst_req, 1'b0, "R1");
   endtask

   task automatic arm();
      @(negedge clk); arm_set = 1; @(negedge clk); arm_set = 0; armed_m = 1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      chk(rom_sel, 1'b0, "R1");
      // R8: disarmed, counter runs but never requests
      for (int i = 0; i < 3*DIV; i++) cyc(1, 0, 0, 0, 0, "R8");
      arm();
      // R2/R10: free running timeouts, with idle gaps (R11)
      for (int i = 0; i < 3*DIV; i++) begin
         cyc(1, 0, 0, 0, 0, "R2");
         for (int g = 0; g < i % 3; g++) cyc(0, 0, 0, 0, 0, "R11");
      end
      // R3: clear after every possible number of ticks
      for (int k = 0; k <= DIV+1; k++) begin
         cyc(0, 1, 0, RA, 8'h01, "R3");
         for (int i = 0; i < k; i++) cyc(1, 0, 0, 0, 0, "R3");
      end
      cyc(0, 1, 0, RA, 8'h01, "R3");
      for (int i = 0; i < DIV; i++) cyc(1, 0, 0, 0, 0, "R10");
      // R4: clear bit 0 ignored regardless of other bits
      for (int d = 0; d < 256; d += 2) begin
         cyc(0, 1, 0, RA, 8'(d), "R4");
         cyc(1, 0, 0, 0, 0, "R4");
      end
      // R5: other addresses with bit set ignored
      for (int a = 0; a < 16; a++) begin
         if (16'(RA - 8 + a) != RA) cyc(0, 1, 0, 16'(RA - 8 + a), 8'hFF, "R5");
         cyc(1, 0, 0, 0, 0, "R5");
      end
      // R6: clear with tick at every count position
      for (int k = 0; k < DIV; k++) begin
         cyc(0, 1, 0, RA, 8'h01, "R6");
         for (int i = 0; i < k; i++) cyc(1, 0, 0, 0, 0, "R6");
         cyc(1, 1, 0, RA, 8'h01, "R6");
         for (int i = 0; i < DIV; i++) cyc(1, 0, 0, 0, 0, "R6");
      end
      // R7: back-to-back ticks around a timeout; request one cycle wide
      for (int i = 0; i < 2*DIV; i++) cyc(1, 0, 0, 0, 0, "R7");
      // R9: reads of the register and of neighbours, with ticks
      for (int a = 0; a < 8; a++) begin
         cyc(1, 0, 1, 16'(RA - 4 + a), 8'h00, "R9");
         cyc(0, 0, 1, RA, 8'h00, "R9");
      end
      for (int i = 0; i < DIV; i++) cyc(1, 0, 0, 0, 0, "R9");
      // R1: reset mid-count clears count and arm latch
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "R1");
      do_reset();
      arm();
      for (int i = 0; i < 2*DIV; i++) cyc(1, 0, 0, 0, 0, "R1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule